// File: doc/BRIEF.md
# Four-Channel Time-Sliced Field-Limited Capture Writer

This block takes four pixel streams that share one pixel rate but arrive with unrelated phases. It merges them into the single write port of one frame buffer. Each channel has a pixel-rate clock, a 16-bit pixel and a video-enable input. On each rising edge of its pixel clock, seen through a synchroniser, the pixel is captured into that channel's one-pixel holding register. A fast system clock runs at eight times the pixel rate and turns a fixed eight-slot schedule. Each channel owns two adjacent slots. In the first slot of its pair, the pending pixel of that channel is either written or dropped.

Field selection needs no resynchronisation FIFOs. Each channel counts the pixels it has written since the last frame-start pulse. Once that count reaches one field's worth, the channel stops writing until the next pulse. Each channel therefore holds exactly one complete field per frame, whatever its phase. The frame-start input is active low. While it is low, the per-channel state is cleared. Its rising edge flips a bank bit that tells the ping-pong buffer which memory to write.

Two layouts are available. In quad mode each channel fills its own quadrant of a 2×QW by 2×QH image. In single mode only the selected channel writes, and it fills the whole image.

Top module: `vcap_writer`

## Requirements
- R1: While `rst` is high and on the clock after it, `wr_en` is 0. After reset the bank bit is 0 and the slot counter restarts at slot 0.
- R2: A rising edge of `ch_pclk[c]` is detected through a three-stage synchroniser. On the second clock after the edge is first sampled, the pixel and enable present on the inputs are captured. The pixel written for channel c is exactly that captured value.
- R3: The slot counter steps 0..7 on every clock after reset. Channel c is served only when the slot is 2c, the first of its pair. A write decided in that cycle appears on the write outputs one clock later.
- R4: A captured pixel whose enable was low is consumed in its slot without a write.
- R5: Within one frame, a channel writes at most FIELD_PIX pixels. Once its count equals FIELD_PIX, further pixels of that channel are discarded.
- R6: While `frame_start_n` is low, no write is issued, and every channel's count, row and column return to zero.
- R7: `wr_bank` carries the bank bit at the time of the write. The bit is 0 after reset and inverts on each clock where `frame_start_n` is high after having been low.
- R8: In quad mode (`quad_mode`=1), channel c's origin is x0=(c mod 2)·QW and y0=(c div 2)·QH, so channel 0 is top-left and channel 3 is bottom-right. Its write address is (y0+row)·2QW + x0+col.
- R9: In single mode (`quad_mode`=0), only channel `ch_sel` writes, to address row·2QW+col. The pixels of the other channels are discarded.
- R10: After each write, col increments. It wraps to 0 at QW in quad mode or at 2QW in single mode, and the row then increments. The row wraps to 0 at QH in quad mode or at 2QH in single mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, eight times the pixel rate |
| rst | input | 1 | Synchronous active-high reset |
| frame_start_n | input | 1 | Active-low frame-start pulse |
| quad_mode | input | 1 | 1 = four quadrants, 0 = one full image |
| ch_sel | input | 2 | Channel written in single mode |
| ch_pclk | input | 4 | Per-channel pixel clocks, asynchronous |
| ch_data | input | 64 | Per-channel pixels, channel c in bits 16c+15..16c |
| ch_ven | input | 4 | Per-channel video enable |
| wr_en | output | 1 | Write strobe to the frame buffer |
| wr_bank | output | 1 | Buffer bank selected for this write |
| wr_addr | output | 19 | Write address |
| wr_data | output | 16 | Pixel written |

## Verification
The assertions rely on three properties of the inputs. `frame_start_n`, `quad_mode` and `ch_sel` are synchronous to `clk`. Each pixel clock has a period of eight slot clocks. Pixel and enable stay stable for a full pixel period after the rising edge. The bench meets these conditions by driving each pixel clock as a four-high, four-low wave with its own phase, changing data only on that wave's rising edge. It changes mode and channel select only while the frame-start pulse is low. A behavioural model then predicts, on every clock, whether a write happens, and if so its address, pixel and bank.

// File: rtl/vcap_pkg.sv
package vcap_pkg;
  localparam int unsigned PIX_W        = 16;
  localparam int unsigned SLOTS_PER_CH = 2;

  // Quadrant origin: even channels sit left, channels 2 and 3 sit lower.
  function automatic int unsigned quad_x0(int unsigned ch, int unsigned qw);
    return (ch % 2) * qw;
  endfunction

  function automatic int unsigned quad_y0(int unsigned ch, int unsigned qh);
    return (ch / 2) * qh;
  endfunction
endpackage

// File: rtl/vcap_lane.sv
// One channel: pixel-clock synchroniser and one-pixel holding register.
module vcap_lane #(
  parameter int unsigned PW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pclk,
  input  logic [PW-1:0] din,
  input  logic          ven,
  input  logic          take,
  output logic          pend,
  output logic [PW-1:0] pix,
  output logic          pix_ven
);
  logic [2:0] sync_q;
  logic       rise;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[1:0], pclk};
  end

  assign rise = sync_q[1] & ~sync_q[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      pix     <= '0;
      pix_ven <= 1'b0;
    end else if (rise) begin
      pend    <= 1'b1;
      pix     <= din;
      pix_ven <= ven;
    end else if (take) begin
      pend    <= 1'b0;
    end
  end
endmodule

// File: rtl/vcap_place.sv
// One channel: per-frame pixel count and raster position, address forming.
module vcap_place
  import vcap_pkg::*;
#(
  parameter int unsigned CH    = 0,
  parameter int unsigned QW    = 320,
  parameter int unsigned QH    = 240,
  parameter int unsigned IMG_W = 640,
  parameter int unsigned IMG_H = 480,
  parameter int unsigned LIM   = 864*287,
  parameter int unsigned AW    = 19,
  parameter int unsigned CW    = 18,
  parameter int unsigned XW    = 10,
  parameter int unsigned YW    = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          adv,
  input  logic          quad,
  output logic [AW-1:0] addr,
  output logic          full,
  output logic [CW-1:0] cnt
);
  localparam int unsigned X0   = quad_x0(CH, QW);
  localparam int unsigned Y0   = quad_y0(CH, QH);
  localparam int unsigned BASE = Y0 * IMG_W + X0;

  logic [XW-1:0] col, col_last;
  logic [YW-1:0] row, row_last;

  always_comb begin
    col_last = quad ? XW'(QW - 1) : XW'(IMG_W - 1);
    row_last = quad ? YW'(QH - 1) : YW'(IMG_H - 1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      col <= '0;
      row <= '0;
    end else if (adv) begin
      cnt <= cnt + 1'b1;
      if (col == col_last) begin
        col <= '0;
        row <= (row == row_last) ? '0 : row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end

  assign full = (cnt >= CW'(LIM));

  always_comb begin
    addr = AW'(row) * AW'(IMG_W) + AW'(col);
    if (quad) addr = addr + AW'(BASE);
  end
endmodule

// File: rtl/vcap_writer.sv
module vcap_writer
  import vcap_pkg::*;
#(
  parameter  int unsigned NCH       = 4,
  parameter  int unsigned QW        = 320,
  parameter  int unsigned QH        = 240,
  parameter  int unsigned FIELD_PIX = 864*287,
  parameter  int unsigned PW        = PIX_W,
  localparam int unsigned IMG_W     = 2 * QW,
  localparam int unsigned IMG_H     = QH * (NCH / 2),
  localparam int unsigned AW        = $clog2(IMG_W * IMG_H),
  localparam int unsigned CHW       = $clog2(NCH),
  localparam int unsigned NSLOT     = NCH * SLOTS_PER_CH,
  localparam int unsigned SW        = $clog2(NSLOT),
  localparam int unsigned CW        = $clog2(FIELD_PIX + 1),
  localparam int unsigned XW        = $clog2(IMG_W),
  localparam int unsigned YW        = $clog2(IMG_H)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start_n,
  input  logic              quad_mode,
  input  logic [CHW-1:0]    ch_sel,
  input  logic [NCH-1:0]    ch_pclk,
  input  logic [NCH*PW-1:0] ch_data,
  input  logic [NCH-1:0]    ch_ven,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [AW-1:0]     wr_addr,
  output logic [PW-1:0]     wr_data
);
  logic [SW-1:0]     slot_q;
  logic [CHW-1:0]    cur_ch, wr_ch_q;
  logic              first_slot, do_wr;
  logic              fn_q, bank_q;
  logic [NCH-1:0]    pend, pv, full, take, adv;
  logic [PW-1:0]     pix  [NCH];
  logic [AW-1:0]     addr [NCH];
  logic [NCH*CW-1:0] cnt_flat;

  // Slot schedule: channel c owns slots 2c and 2c+1.
  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= (slot_q == SW'(NSLOT - 1)) ? '0 : slot_q + 1'b1;
  end

  assign cur_ch     = CHW'(slot_q / SW'(SLOTS_PER_CH));
  assign first_slot = (slot_q % SW'(SLOTS_PER_CH)) == '0;

  assign do_wr = first_slot && pend[cur_ch] && pv[cur_ch] && frame_start_n &&
                 !full[cur_ch] && (quad_mode || (ch_sel == cur_ch));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign take[g] = first_slot && (cur_ch == CHW'(g));
    assign adv[g]  = do_wr && (cur_ch == CHW'(g));

    vcap_lane #(.PW(PW)) u_lane (
      .clk(clk), .rst(rst), .pclk(ch_pclk[g]), .din(ch_data[g*PW +: PW]),
      .ven(ch_ven[g]), .take(take[g]), .pend(pend[g]), .pix(pix[g]),
      .pix_ven(pv[g])
    );

    vcap_place #(
      .CH(g), .QW(QW), .QH(QH), .IMG_W(IMG_W), .IMG_H(IMG_H),
      .LIM(FIELD_PIX), .AW(AW), .CW(CW), .XW(XW), .YW(YW)
    ) u_place (
      .clk(clk), .rst(rst), .clr(!frame_start_n), .adv(adv[g]),
      .quad(quad_mode), .addr(addr[g]), .full(full[g]),
      .cnt(cnt_flat[g*CW +: CW])
    );
  end

  // Bank bit flips at the end of each frame-start pulse.
  always_ff @(posedge clk) begin
    if (rst) begin
      fn_q   <= 1'b1;
      bank_q <= 1'b0;
    end else begin
      fn_q <= frame_start_n;
      if (frame_start_n && !fn_q) bank_q <= ~bank_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_bank <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
      wr_ch_q <= '0;
    end else begin
      wr_en   <= do_wr;
      wr_ch_q <= cur_ch;
      if (do_wr) begin
        wr_bank <= bank_q;
        wr_addr <= addr[cur_ch];
        wr_data <= pix[cur_ch];
      end
    end
  end
endmodule

module vcap_writer_chk #(
  parameter int unsigned NCH = 4,
  parameter int unsigned SW  = 3,
  parameter int unsigned CHW = 2,
  parameter int unsigned CW  = 18,
  parameter int unsigned LIM = 864*287,
  parameter int unsigned SPC = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              frame_n,
  input logic              quad,
  input logic [CHW-1:0]    sel,
  input logic              wr_en,
  input logic [SW-1:0]     slot,
  input logic [CHW-1:0]    wr_ch,
  input logic [NCH*CW-1:0] cnt_flat
);
  assert_reset_idle_R1: assert property (@(posedge clk) rst |=> !wr_en);

  assert_slot_owner_R3: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (($past(slot) % SW'(SPC)) == '0) &&
              (CHW'($past(slot) / SW'(SPC)) == wr_ch));

  assert_frame_gap_R6: assert property (@(posedge clk) disable iff (rst)
    !frame_n |=> !wr_en);

  assert_single_sel_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !$past(quad)) |-> (wr_ch == $past(sel)));

  for (genvar g = 0; g < NCH; g++) begin : g_cnt
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (rst)
      cnt_flat[g*CW +: CW] <= CW'(LIM));
  end
endmodule

bind vcap_writer vcap_writer_chk #(
  .NCH(NCH), .SW(SW), .CHW(CHW), .CW(CW), .LIM(FIELD_PIX), .SPC(SLOTS_PER_CH)
) u_chk (
  .clk(clk), .rst(rst), .frame_n(frame_start_n), .quad(quad_mode),
  .sel(ch_sel), .wr_en(wr_en), .slot(slot_q), .wr_ch(wr_ch_q),
  .cnt_flat(cnt_flat)
);

// File: tb/tb_vcap_writer.sv
module tb_vcap_writer;
  localparam int QW = 4, QH = 3, LIM = 20, NCH = 4, PW = 16;
  localparam int IMG_W = 2*QW, AW = $clog2(2*QW*2*QH);

  logic clk = 0, rst = 1, frame_start_n = 1, quad_mode = 1;
  logic [1:0] ch_sel = 0;
  logic [NCH-1:0] ch_pclk = 0, ch_ven = 0;
  logic [NCH*PW-1:0] ch_data = 0;
  logic wr_en, wr_bank;
  logic [AW-1:0] wr_addr;
  logic [PW-1:0] wr_data;

  vcap_writer #(.NCH(NCH), .QW(QW), .QH(QH), .FIELD_PIX(LIM)) dut (
    .clk(clk), .rst(rst), .frame_start_n(frame_start_n), .quad_mode(quad_mode),
    .ch_sel(ch_sel), .ch_pclk(ch_pclk), .ch_data(ch_data), .ch_ven(ch_ven),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data));

  always #10 clk = ~clk;

  int errors = 0, checks = 0, t = 0;
  bit done = 0;
  int phase [NCH] = '{0, 2, 5, 7};
  int pixn [NCH];
  // model state
  int m_pend[NCH], m_dat[NCH], m_ven[NCH], m_cnt[NCH], m_row[NCH], m_col[NCH];
  int a_t[NCH], a_dat[NCH], a_ven[NCH], m_prev[NCH];
  int m_slot, m_bank, m_prevfn;
  int e_en, e_addr, e_dat, e_bank;
  string e_tag, e_atag;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0d actual=%0d expected=%0d", tag, t, act, exp);
    end
  endtask

  task automatic model_edge();
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        m_pend[c] = 0; m_cnt[c] = 0; m_row[c] = 0; m_col[c] = 0;
        a_t[c] = -1; m_prev[c] = 0;
      end
      m_slot = 0; m_bank = 0; m_prevfn = 1; e_en = 0; e_tag = "R1";
      return;
    end
    e_en = 0; e_tag = "R3";
    if (m_slot % 2 == 0) begin
      int c = m_slot / 2;
      if (m_pend[c] != 0) begin
        if (m_ven[c] == 0) e_tag = "R4";
        else if (!frame_start_n) e_tag = "R6";
        else if (m_cnt[c] >= LIM) e_tag = "R5";
        else if (!quad_mode && ch_sel != 2'(c)) e_tag = "R9";
        else begin
          int cmax = quad_mode ? QW : 2*QW;
          int rmax = quad_mode ? QH : 2*QH;
          e_en = 1; e_dat = m_dat[c]; e_bank = m_bank;
          e_atag = quad_mode ? "R8" : "R9";
          if (m_cnt[c] > 0 && m_col[c] == 0) e_atag = "R10";
          if (quad_mode) e_addr = ((c/2)*QH + m_row[c])*IMG_W + (c%2)*QW + m_col[c];
          else           e_addr = m_row[c]*IMG_W + m_col[c];
          m_cnt[c]++; m_col[c]++;
          if (m_col[c] == cmax) begin
            m_col[c] = 0; m_row[c]++;
            if (m_row[c] == rmax) m_row[c] = 0;
          end
        end
      end
      m_pend[c] = 0;
    end
    if (!frame_start_n)
      for (int c = 0; c < NCH; c++) begin m_cnt[c] = 0; m_row[c] = 0; m_col[c] = 0; end
    for (int c = 0; c < NCH; c++) begin
      if (a_t[c] == t) begin m_pend[c] = 1; m_dat[c] = a_dat[c]; m_ven[c] = a_ven[c]; a_t[c] = -1; end
      if (ch_pclk[c] && m_prev[c] == 0) begin
        a_t[c] = t + 2; a_dat[c] = int'(ch_data[c*PW +: PW]); a_ven[c] = int'(ch_ven[c]);
      end
      m_prev[c] = int'(ch_pclk[c]);
    end
    if (frame_start_n && m_prevfn == 0) m_bank ^= 1;
    m_prevfn = int'(frame_start_n);
    m_slot = (m_slot + 1) % 8;
  endtask

  task automatic run(int n, bit r, bit fn);
    for (int k = 0; k < n; k++) begin
      rst = r; frame_start_n = fn;
      for (int c = 0; c < NCH; c++) begin
        int p = (t + phase[c]) % 8;
        ch_pclk[c] = (p < 4);
        if (p == 0) begin
          pixn[c]++;
          ch_data[c*PW +: PW] = 16'(c*4096 + pixn[c]);
          ch_ven[c] = !((c == 1 && pixn[c] % 7 == 3) || (c == 3 && pixn[c] % 5 == 0));
        end
      end
      model_edge();
      @(negedge clk);
      check(e_tag, int'(wr_en), e_en);              // R1 R3 R4 R5 R6 R9
      if (e_en != 0 && wr_en) begin
        check(e_atag, int'(wr_addr), e_addr);       // R8 R9 R10
        check("R2", int'(wr_data), e_dat);
        check("R7", int'(wr_bank), e_bank);
      end
      t++;
    end
  endtask

  initial begin
    for (int c = 0; c < NCH; c++) pixn[c] = 0;
    @(negedge clk);
    run(5, 1, 1);                 // R1 reset
    run(250, 0, 1);               // quad frame, limit reached (R5)
    run(3, 0, 0);                 // R6 gap
    run(200, 0, 1);               // bank 1 (R7)
    quad_mode = 0; ch_sel = 2;
    run(2, 0, 0);
    run(250, 0, 1);               // single mode, column wrap (R9 R10)
    ch_sel = 1;
    run(2, 0, 0);
    run(150, 0, 1);               // single mode with enable gaps (R4)
    run(3, 1, 1);                 // mid-run reset (R1)
    run(100, 0, 1);
    quad_mode = 1;
    run(2, 0, 0);
    run(100, 0, 1);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R3 actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule